// File: doc/BRIEF.md
# Dual-Redundant Controller Failover Selector

This block picks which of two redundant controllers is allowed to drive the outputs of a dual-redundant system. Each controller is watched by its own health monitor, which hands this block two flags: a sticky fault flag that stays high once the controller has ever misbehaved, and a live fault flag that is high only while a fault is present. An operator override can force either controller regardless of health.

The choice is registered on the system clock. The result is one select bit, so exactly one controller is active at any time. A parameter names the controller that is active after reset and whenever nothing has gone wrong. When both controllers have a sticky fault, the live flags decide. If they do not, a build option chooses the tie result: either the initial controller or the low bit of a free-running 8-bit pseudo-random shift register.

Top module: `failover_selector`

## Requirements
- R1: While `rst_n` is low, `sel` equals the parameter `INIT_SEL` (0 = controller one, 1 = controller two; default 0).
- R2: `sel` is registered. The value after a rising clock edge depends only on the inputs sampled at that edge.
- R3: When `ovr_en` is high, the next `sel` equals `ovr_pick`, whatever the fault flags are.
- R4: With `ovr_en` low and both sticky flags low, the next `sel` is `INIT_SEL`.
- R5: With `ovr_en` low, `stk_fault_a` high and `stk_fault_b` low, the next `sel` is 1. A controller with a sticky fault is not chosen again on this path.
- R6: With `ovr_en` low, `stk_fault_b` high and `stk_fault_a` low, the next `sel` is 0.
- R7: With `ovr_en` low and both sticky flags high, if exactly one live flag is high (1 = currently faulty), the next `sel` picks the other controller.
- R8: With `ovr_en` low, both sticky flags high, and the live flags equal, the next `sel` is `INIT_SEL` when `USE_LFSR` is 0.
- R9: When `USE_LFSR` is 1, the R8 case instead takes bit 0 of an 8-bit register with these properties:
  - Reset loads the register with `LFSR_SEED` (default 0xA5).
  - Out of reset it advances on every clock by shifting left.
  - The bit shifted in is the XOR of bits 7, 5, 4 and 3.
  - The tie uses the register value held before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stk_fault_a | input | 1 | Sticky fault flag of controller one |
| stk_fault_b | input | 1 | Sticky fault flag of controller two |
| live_fault_a | input | 1 | Present fault flag of controller one (1 = faulty now) |
| live_fault_b | input | 1 | Present fault flag of controller two (1 = faulty now) |
| ovr_en | input | 1 | Manual override enable, low when unused |
| ovr_pick | input | 1 | Controller forced while override is on |
| sel | output | 1 | Active controller: 0 = one, 1 = two |

## Verification
The embedded properties check every cycle that the registered choice obeys the priority order: override, then the live-flag decision for a double fault, then single-fault failover, then the idle default. They also check that the first cycle out of reset shows the initial controller.

The tie result under the pseudo-random option depends on the register's history since reset. Only the bench shows that this history is right, by carrying its own model of the sequence. The bench also shows the reset value held across a long reset, and long runs where a sticky fault holds the selection away from the failed controller.

// File: rtl/fos_pkg.sv
package fos_pkg;
   typedef enum logic {
      CTRL_ONE = 1'b0,
      CTRL_TWO = 1'b1
   } ctrl_e;

   function automatic ctrl_e to_ctrl(input logic b);
      return b ? CTRL_TWO : CTRL_ONE;
   endfunction
endpackage

// File: rtl/fos_lfsr.sv
module fos_lfsr #(
   parameter int unsigned          WIDTH = 8,
   parameter logic [WIDTH-1:0]     SEED  = 8'hA5,
   parameter logic [WIDTH-1:0]     TAPS  = 8'hB8
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [WIDTH-1:0] state
);
   localparam int unsigned MSB = WIDTH - 1;

   if (WIDTH < 3) begin : g_bad_width
      $error("fos_lfsr: WIDTH must be at least 3");
   end
   if (SEED == '0) begin : g_bad_seed
      $error("fos_lfsr: SEED must be nonzero");
   end
   if (TAPS[MSB] == 1'b0) begin : g_bad_taps
      $error("fos_lfsr: TAPS must include the top bit");
   end

   logic feedback;
   assign feedback = ^(state & TAPS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= SEED;
      else        state <= {state[MSB-1:0], feedback};
   end

   // R9: never locks up in the all-zero state
   lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state != '0);
endmodule

// File: rtl/fos_arbiter.sv
module fos_arbiter
   import fos_pkg::*;
#(
   parameter bit INIT_SEL = 1'b0
) (
   input  logic  stk_a,
   input  logic  stk_b,
   input  logic  live_a,
   input  logic  live_b,
   input  logic  ovr_en,
   input  logic  ovr_pick,
   input  logic  tie_bit,
   output ctrl_e pick
);
   localparam ctrl_e INIT_CTRL = INIT_SEL ? CTRL_TWO : CTRL_ONE;

   logic both_failed;
   logic live_split;
   assign both_failed = stk_a & stk_b;
   assign live_split  = live_a ^ live_b;

   always_comb begin
      if (ovr_en)           pick = to_ctrl(ovr_pick);
      else if (both_failed) pick = live_split ? to_ctrl(live_a) : to_ctrl(tie_bit);
      else if (stk_a)       pick = CTRL_TWO;
      else if (stk_b)       pick = CTRL_ONE;
      else                  pick = INIT_CTRL;
   end
endmodule

// File: rtl/failover_selector.sv
module failover_selector
   import fos_pkg::*;
#(
   parameter bit                    INIT_SEL  = 1'b0,
   parameter bit                    USE_LFSR  = 1'b0,
   parameter int unsigned           LFSR_W    = 8,
   parameter logic [LFSR_W-1:0]     LFSR_SEED = 8'hA5,
   parameter logic [LFSR_W-1:0]     LFSR_TAPS = 8'hB8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stk_fault_a,
   input  logic stk_fault_b,
   input  logic live_fault_a,
   input  logic live_fault_b,
   input  logic ovr_en,
   input  logic ovr_pick,
   output logic sel
);
   localparam ctrl_e INIT_CTRL = INIT_SEL ? CTRL_TWO : CTRL_ONE;

   logic  tie_bit;
   ctrl_e next_pick;
   ctrl_e sel_q;

   if (USE_LFSR) begin : g_lfsr_tie
      logic [LFSR_W-1:0] lfsr_state;
      fos_lfsr #(
         .WIDTH (LFSR_W),
         .SEED  (LFSR_SEED),
         .TAPS  (LFSR_TAPS)
      ) i_fos_lfsr (
         .clk   (clk),
         .rst_n (rst_n),
         .state (lfsr_state)
      );
      assign tie_bit = lfsr_state[0];
   end else begin : g_fixed_tie
      assign tie_bit = INIT_SEL;
   end

   fos_arbiter #(
      .INIT_SEL (INIT_SEL)
   ) i_fos_arbiter (
      .stk_a    (stk_fault_a),
      .stk_b    (stk_fault_b),
      .live_a   (live_fault_a),
      .live_b   (live_fault_b),
      .ovr_en   (ovr_en),
      .ovr_pick (ovr_pick),
      .tie_bit  (tie_bit),
      .pick     (next_pick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q <= INIT_CTRL;
      else        sel_q <= next_pick;
   end

   assign sel = sel_q;

   // R1
   reset_init_chk: assert property (@(posedge clk)
      $rose(rst_n) |-> (sel == INIT_SEL));
   // R3
   ovr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_en |=> (sel == $past(ovr_pick)));
   // R4
   idle_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovr_en && !stk_fault_a && !stk_fault_b) |=> (sel == INIT_SEL));
   // R5
   fail_a_away_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovr_en && stk_fault_a && !stk_fault_b) |=> (sel == 1'b1));
   // R6
   fail_b_away_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovr_en && stk_fault_b && !stk_fault_a) |=> (sel == 1'b0));
   // R7
   live_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovr_en && stk_fault_a && stk_fault_b && (live_fault_a != live_fault_b))
      |=> (sel == $past(live_fault_a)));

   if (!USE_LFSR) begin : g_tie_chk
      // R8
      tie_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!ovr_en && stk_fault_a && stk_fault_b && (live_fault_a == live_fault_b))
         |=> (sel == INIT_SEL));
   end
endmodule

// File: tb/test_failover_selector.sv
module test_failover_selector;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic stk_a = 1'b0, stk_b = 1'b0, live_a = 1'b0, live_b = 1'b0;
   logic ovr_en = 1'b0, ovr_pick = 1'b0;
   logic sel_fix, sel_rnd;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [7:0] lfsr_m;

   always #5 clk = ~clk;

   failover_selector i_failover_selector (
      .clk(clk), .rst_n(rst_n),
      .stk_fault_a(stk_a), .stk_fault_b(stk_b),
      .live_fault_a(live_a), .live_fault_b(live_b),
      .ovr_en(ovr_en), .ovr_pick(ovr_pick), .sel(sel_fix)
   );

   failover_selector #(.INIT_SEL(1'b1), .USE_LFSR(1'b1)) i_failover_selector_rnd (
      .clk(clk), .rst_n(rst_n),
      .stk_fault_a(stk_a), .stk_fault_b(stk_b),
      .live_fault_a(live_a), .live_fault_b(live_b),
      .ovr_en(ovr_en), .ovr_pick(ovr_pick), .sel(sel_rnd)
   );

   function automatic logic [7:0] lfsr_next(input logic [7:0] s);
      return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
   endfunction

   function automatic logic model(input logic init, input logic tie);
      if (ovr_en) return ovr_pick;                          // R3
      if (stk_a && stk_b) begin
         if (live_a != live_b) return live_a;               // R7
         return tie;                                        // R8 / R9
      end
      if (stk_a) return 1'b1;                               // R5
      if (stk_b) return 1'b0;                               // R6
      return init;                                          // R4
   endfunction

   function automatic string tag_of();
      if (ovr_en) return "R3";
      if (stk_a && stk_b) return (live_a != live_b) ? "R7" : "R8/R9";
      if (stk_a) return "R5";
      if (stk_b) return "R6";
      return "R4";
   endfunction

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   // drive at negedge, clock once, sample at next negedge (R2: one register)
   task automatic step(input logic sa, input logic sb, input logic la, input logic lb,
                       input logic oe, input logic op);
      logic e_fix, e_rnd;
      string t;
      stk_a = sa; stk_b = sb; live_a = la; live_b = lb; ovr_en = oe; ovr_pick = op;
      e_fix = model(1'b0, 1'b0);
      e_rnd = model(1'b1, lfsr_m[0]);
      t = tag_of();
      @(posedge clk);
      @(negedge clk);
      check({t, " R2 fixed"}, sel_fix, e_fix);
      check({t, " R2 R9 lfsr"}, sel_rnd, e_rnd);
      lfsr_m = lfsr_next(lfsr_m);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R1 reset values held across reset, with activity on the inputs
      stk_a = 1'b1; ovr_en = 1'b1; ovr_pick = 1'b1;
      @(negedge clk);
      check("R1 fixed", sel_fix, 1'b0);
      check("R1 lfsr", sel_rnd, 1'b1);
      stk_a = 1'b0; ovr_en = 1'b0; ovr_pick = 1'b0;
      rst_n = 1'b1;
      lfsr_m = 8'hA5;
      // R4 idle
      step(0,0,0,0,0,0);
      step(0,0,1,1,0,0);
      // R5 sticky fault on one: held away for many cycles, live flag clearing
      step(1,0,1,0,0,0);
      for (int i = 0; i < 5; i++) step(1,0,0,0,0,0);
      // R6
      step(0,1,0,1,0,0);
      step(0,1,0,0,0,0);
      // R3 override beats faults
      step(1,0,0,0,1,0);
      step(0,1,0,0,1,1);
      step(1,1,1,0,1,1);
      // R7 live decision
      step(1,1,1,0,0,0);
      step(1,1,0,1,0,0);
      // R8/R9 ties over many LFSR values
      for (int i = 0; i < 20; i++) step(1,1,i[0],i[0],0,0);
      // random mix
      for (int i = 0; i < 600; i++) begin
         step(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
              ($urandom % 4) == 0, 1'($urandom));
      end
      // R1 again: reset mid-run restores initial choice and LFSR seed
      stk_a = 1'b1; stk_b = 1'b0; ovr_en = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 re-reset fixed", sel_fix, 1'b0);
      check("R1 re-reset lfsr", sel_rnd, 1'b1);
      rst_n = 1'b1;
      lfsr_m = 8'hA5;
      for (int i = 0; i < 10; i++) step(1,1,0,0,0,0);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule